// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the bit-level core of an SPI master. It takes parallel transmit words through a valid/ready handshake and shifts them out on `mosi`. At the same time it collects bits from `miso` into received words. `sck` comes from a reload timer, so one SCK period lasts 2×(reload+1) module clocks. Static configuration inputs select the following:

- the word length, from 1 to 32 bits
- the SCK idle level
- which SCK edge samples the data
- the bit order
- the level that `mosi` rests at
- separate switches that turn off the transmit path and the receive path

With transmit enabled, the block runs a transfer for as long as words keep arriving. Each new word is taken at the boundary of the previous word, with no gap in SCK. When a boundary comes and no word is offered, the transfer ends and an underflow strobe is raised. With transmit off and receive on, the block clocks only after a nonzero byte count is written. It then counts that budget down, one word at a time, and `mosi` stays at its idle level throughout.

Top module: `spi_shift_engine`

## Requirements
- R1: A word is `cfg_len`+1 bits long (`cfg_len` from 0 to 31). A word takes exactly 2×(`cfg_len`+1) SCK toggles, and `word_end` pulses for one cycle after the last toggle. `rx_valid` never pulses without `word_end`.
- R2: The first SCK toggle comes `cfg_reload`+1 clocks after the word is accepted, and each later toggle comes `cfg_reload`+1 clocks after the previous one.
- R3: While the engine is idle, `sck` rests at `cfg_cpol`: 0 idles low, 1 idles high.
- R4: With `cfg_lead_sample`=1, `miso` is sampled on the odd toggles of a word (the leading edges) and `mosi` moves on the even toggles. With `cfg_lead_sample`=0 this is reversed, and the first bit is already on `mosi` before the first toggle. The received word appears on `rx_data`, with unused upper bits at zero.
- R5: With `cfg_msb_first`=1, bit `cfg_len` is sent and received first, then bit `cfg_len`-1, and so on. With `cfg_msb_first`=0, bit 0 goes first.
- R6: With `cfg_rx_off`=1, `rx_valid` never pulses and `rx_data` holds its value. With both `cfg_tx_off`=1 and `cfg_rx_off`=1, no transfer starts.
- R7: With `cfg_tx_off`=1 and `cfg_rx_off`=0, a transfer starts only after `rxreq_wr` writes a nonzero `rxreq_bytes` while `rx_left` is 0. Each word subtracts (`cfg_len`>>3)+1 bytes from `rx_left`, which saturates at 0, and the transfer stops when `rx_left` reaches 0. A request written while `rx_left` is nonzero is ignored.
- R8: `mosi` equals `cfg_idle_val` whenever the engine is idle, and throughout a receive-only transfer.
- R9: `busy` rises in the cycle after a word is accepted to start a transfer. It falls together with the `word_end` of the final word.
- R10: When a word boundary arrives with transmit enabled and `tx_valid` low, `tx_underflow` pulses for one cycle, `busy` falls in that same cycle, and the engine stops.
- R11: `tx_ready` is high only when transmit is enabled and the engine is either idle or at its last toggle. A word offered at the last toggle continues the transfer without a gap in SCK.
- R12: After reset, `busy`, `rx_valid`, `word_end`, `tx_underflow` and `rx_left` are 0, and `rx_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 5 | Bits per word minus one |
| cfg_reload | input | 16 | SCK half-period reload value |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_lead_sample | input | 1 | 1: sample on leading edge; 0: sample on trailing edge |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_tx_off | input | 1 | Disable transmit path |
| cfg_rx_off | input | 1 | Disable receive path |
| cfg_idle_val | input | 1 | Level of `mosi` when not shifting |
| tx_data | input | 32 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken at this edge |
| rxreq_wr | input | 1 | Write strobe for the receive-only byte request |
| rxreq_bytes | input | 16 | Number of bytes requested |
| rx_left | output | 16 | Bytes still to be clocked in receive-only mode |
| rx_data | output | 32 | Last received word |
| rx_valid | output | 1 | One-cycle strobe, `rx_data` updated |
| busy | output | 1 | Transfer in progress |
| word_end | output | 1 | One-cycle strobe at the end of each word |
| tx_underflow | output | 1 | One-cycle strobe when transmit data ran out |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong toggle count or a wrong timer reload shows up as a misplaced `sck` edge. The bench's per-clock comparison catches it within one reload period. A wrong bit index or bit order changes `mosi` at the next shift edge, and shows up as a wrong `rx_data` at the next `word_end`. A wrong byte budget shows up in `rx_left` at the end of the first word, and in `busy` at the point where the transfer should stop. A wrong handshake decision at a boundary shows up in the same cycle, as a mismatch on `tx_ready`, `tx_underflow` or `busy`.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [1:0] {
    XM_NONE   = 2'd0,
    XM_TX     = 2'd1,
    XM_RXONLY = 2'd2
  } xfer_mode_e;

  function automatic xfer_mode_e pick_mode(input logic tx_off, input logic rx_off);
    if (!tx_off)      return XM_TX;
    else if (!rx_off) return XM_RXONLY;
    else              return XM_NONE;
  endfunction
endpackage

// File: rtl/spi_baud_timer.sv
module spi_baud_timer #(
  parameter int BR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [BR_W-1:0] reload,
  output logic            tick
);
  logic [BR_W-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (!run || tick)     cnt <= reload;
    else                       cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/spi_edge_seq.sv
module spi_edge_seq #(
  parameter int LEN_W = 5,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_lead_sample,
  output logic [LEN_W-1:0] bit_idx,
  output logic             do_sample,
  output logic             do_shift,
  output logic             last_edge
);
  logic [CNT_W-1:0] ecnt;
  logic             leading;

  // ecnt counts toggles already made in this word; the next one is leading when even
  assign leading   = ~ecnt[0];
  assign last_edge = (ecnt == CNT_W'({cfg_len, 1'b1}));
  assign do_sample = cfg_lead_sample ? leading : ~leading;
  assign do_shift  = cfg_lead_sample ? (~leading && !last_edge)
                                     : (leading && (ecnt != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt    <= '0;
      bit_idx <= '0;
    end else if (load) begin
      ecnt    <= '0;
      bit_idx <= '0;
    end else if (tick) begin
      ecnt <= ecnt + 1'b1;
      if (do_shift) bit_idx <= bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/spi_rx_budget.sv
module spi_rx_budget #(
  parameter int REQ_W  = 16,
  parameter int BYTE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic [REQ_W-1:0]  req_bytes,
  input  logic              consume,
  input  logic [BYTE_W-1:0] word_bytes,
  output logic [REQ_W-1:0]  left,
  output logic              last_word
);
  logic accept;

  assign accept    = req_wr && (left == '0) && (req_bytes != '0);
  assign last_word = (left <= REQ_W'(word_bytes));

  always_ff @(posedge clk) begin
    if (rst)          left <= '0;
    else if (accept)  left <= req_bytes;
    else if (consume) left <= last_word ? '0 : left - REQ_W'(word_bytes);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int BR_W     = 16,
  parameter int REQ_W    = 16,
  parameter int LEN_W    = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [BR_W-1:0]     cfg_reload,
  input  logic                cfg_cpol,
  input  logic                cfg_lead_sample,
  input  logic                cfg_msb_first,
  input  logic                cfg_tx_off,
  input  logic                cfg_rx_off,
  input  logic                cfg_idle_val,
  input  logic [MAX_BITS-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic                rxreq_wr,
  input  logic [REQ_W-1:0]    rxreq_bytes,
  output logic [REQ_W-1:0]    rx_left,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                busy,
  output logic                word_end,
  output logic                tx_underflow,
  output logic                sck,
  output logic                mosi,
  input  logic                miso
);
  localparam int BYTE_W = (LEN_W > 3) ? LEN_W - 2 : 1;

  xfer_mode_e          mode;
  logic                tick, do_sample, do_shift, last_edge, last_word;
  logic [LEN_W-1:0]    bit_idx, pos;
  logic [BYTE_W-1:0]   wbytes;
  logic                end_word, start, cont, load, sample_now;
  logic                busy_q, sck_q, we_q, rv_q, uf_q;
  logic [MAX_BITS-1:0] tx_word, rx_shift, rx_next, rx_data_q;

  assign mode    = pick_mode(cfg_tx_off, cfg_rx_off);
  assign wbytes  = BYTE_W'(cfg_len >> 3) + BYTE_W'(1);
  assign pos     = cfg_msb_first ? (cfg_len - bit_idx) : bit_idx;

  spi_baud_timer #(.BR_W(BR_W)) timer_i (
    .clk(clk), .rst(rst), .run(busy_q), .reload(cfg_reload), .tick(tick)
  );

  spi_edge_seq #(.LEN_W(LEN_W)) seq_i (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .cfg_len(cfg_len),
    .cfg_lead_sample(cfg_lead_sample), .bit_idx(bit_idx), .do_sample(do_sample),
    .do_shift(do_shift), .last_edge(last_edge)
  );

  spi_rx_budget #(.REQ_W(REQ_W), .BYTE_W(BYTE_W)) budget_i (
    .clk(clk), .rst(rst), .req_wr(rxreq_wr), .req_bytes(rxreq_bytes),
    .consume(end_word && (mode == XM_RXONLY)), .word_bytes(wbytes),
    .left(rx_left), .last_word(last_word)
  );

  assign end_word = tick && last_edge;
  assign start    = !busy_q && (((mode == XM_TX) && tx_valid) ||
                                ((mode == XM_RXONLY) && (rx_left != '0)));
  assign cont     = end_word && (((mode == XM_TX) && tx_valid) ||
                                 ((mode == XM_RXONLY) && !last_word));
  assign load     = start || cont;
  assign tx_ready = (mode == XM_TX) && (!busy_q || end_word);
  assign sample_now = tick && do_sample && !cfg_rx_off;

  always_comb begin
    rx_next = rx_shift;
    if (sample_now) rx_next[pos] = miso;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      sck_q     <= cfg_cpol;
      tx_word   <= '0;
      rx_shift  <= '0;
      rx_data_q <= '0;
      we_q      <= 1'b0;
      rv_q      <= 1'b0;
      uf_q      <= 1'b0;
    end else begin
      we_q <= end_word;
      rv_q <= end_word && !cfg_rx_off;
      uf_q <= end_word && (mode == XM_TX) && !tx_valid;
      if (start)                busy_q <= 1'b1;
      else if (end_word && !cont) busy_q <= 1'b0;
      if (!busy_q)   sck_q <= cfg_cpol;
      else if (tick) sck_q <= ~sck_q;
      if (load && (mode == XM_TX)) tx_word <= tx_data;
      rx_shift <= load ? '0 : rx_next;
      if (end_word && !cfg_rx_off) rx_data_q <= rx_next;
    end
  end

  assign busy         = busy_q;
  assign sck          = sck_q;
  assign word_end     = we_q;
  assign rx_valid     = rv_q;
  assign tx_underflow = uf_q;
  assign rx_data      = rx_data_q;
  assign mosi         = (busy_q && (mode == XM_TX)) ? tx_word[pos] : cfg_idle_val;
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
  parameter int REQ_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_cpol,
  input logic             cfg_rx_off,
  input logic             cfg_tx_off,
  input logic             cfg_idle_val,
  input logic             tx_ready,
  input logic [REQ_W-1:0] rx_left,
  input logic             rx_valid,
  input logic             busy,
  input logic             word_end,
  input logic             tx_underflow,
  input logic             sck,
  input logic             mosi
);
  p_idle_level_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!busy) |-> (sck == $past(cfg_cpol)));

  p_busy_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> word_end);

  p_rx_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_rx_off) |-> !rx_valid);

  p_mosi_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mosi == cfg_idle_val));

  p_uf_stop_r10: assert property (@(posedge clk) disable iff (rst)
    tx_underflow |-> !busy);

  p_left_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((rx_left != $past(rx_left)) && ($past(rx_left) != '0)) |-> word_end);

  p_no_ready_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_tx_off |-> !tx_ready);

  p_rv_with_end_r1: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> word_end);
endmodule

bind spi_shift_engine spi_shift_engine_chk #(.REQ_W(REQ_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_rx_off(cfg_rx_off),
  .cfg_tx_off(cfg_tx_off), .cfg_idle_val(cfg_idle_val), .tx_ready(tx_ready),
  .rx_left(rx_left), .rx_valid(rx_valid), .busy(busy), .word_end(word_end),
  .tx_underflow(tx_underflow), .sck(sck), .mosi(mosi)
);

// File: tb/spi_shift_engine_tb_top.sv
`timescale 1ns/1ps
module spi_shift_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cfg_len = 5'd7;
  logic [15:0] cfg_reload = 16'd1;
  logic        cfg_cpol = 1'b0, cfg_lead_sample = 1'b1, cfg_msb_first = 1'b1;
  logic        cfg_tx_off = 1'b0, cfg_rx_off = 1'b0, cfg_idle_val = 1'b1;
  logic [31:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic        rxreq_wr = 1'b0;
  logic [15:0] rxreq_bytes = '0;
  logic [15:0] rx_left;
  logic [31:0] rx_data;
  logic        rx_valid, busy, word_end, tx_underflow, sck, mosi;
  logic        miso = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0, done = 0;
  logic [31:0] rx_pat = 32'h0;

  // reference model state
  bit          mb = 0;
  int          t = 0, m_left = 0;
  logic [31:0] w = '0, rxw = '0, e_rx = '0;
  bit          e_we = 0, e_rv = 0, e_uf = 0, e_sck = 0;
  int          brp, n2, k, oldl, kd, bi;
  bit          txm, rxo, exp_mosi, exp_ready;

  always #4 clk = ~clk;

  spi_shift_engine dut_i (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_reload(cfg_reload),
    .cfg_cpol(cfg_cpol), .cfg_lead_sample(cfg_lead_sample),
    .cfg_msb_first(cfg_msb_first), .cfg_tx_off(cfg_tx_off),
    .cfg_rx_off(cfg_rx_off), .cfg_idle_val(cfg_idle_val), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rxreq_wr(rxreq_wr),
    .rxreq_bytes(rxreq_bytes), .rx_left(rx_left), .rx_data(rx_data),
    .rx_valid(rx_valid), .busy(busy), .word_end(word_end),
    .tx_underflow(tx_underflow), .sck(sck), .mosi(mosi), .miso(miso)
  );

  function automatic int posf(input int j);
    return cfg_msb_first ? (int'(cfg_len) - j) : j;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced once per clock
  always @(posedge clk) begin
    if (rst) begin
      mb = 0; t = 0; w = '0; rxw = '0; e_rx = '0; m_left = 0;
      e_we = 0; e_rv = 0; e_uf = 0; e_sck = cfg_cpol;
    end else begin
      brp  = int'(cfg_reload) + 1;
      n2   = 2 * (int'(cfg_len) + 1);
      txm  = !cfg_tx_off;
      rxo  = cfg_tx_off && !cfg_rx_off;
      oldl = m_left;
      e_we = 0; e_rv = 0; e_uf = 0;
      if (mb) begin
        t++;
        if (t % brp == 0) begin
          k = t / brp;
          if (!cfg_rx_off && ((cfg_lead_sample && k % 2 == 1) || (!cfg_lead_sample && k % 2 == 0)))
            rxw[posf((k - 1) / 2)] = miso;
          if (k == n2) begin
            e_we = 1;
            if (!cfg_rx_off) begin e_rv = 1; e_rx = rxw; end
            if (txm) begin
              if (tx_valid) begin w = tx_data; t = 0; rxw = '0; end
              else begin e_uf = 1; mb = 0; end
            end else if (rxo) begin
              m_left = m_left - (int'(cfg_len) / 8 + 1);
              if (m_left < 0) m_left = 0;
              if (m_left != 0) begin t = 0; rxw = '0; end
              else mb = 0;
            end else mb = 0;
          end
        end
      end else begin
        if (txm && tx_valid) begin mb = 1; w = tx_data; t = 0; rxw = '0; end
        else if (rxo && m_left != 0) begin mb = 1; t = 0; rxw = '0; end
      end
      if (rxreq_wr && oldl == 0 && rxreq_bytes != 0) m_left = int'(rxreq_bytes);
      e_sck = mb ? (cfg_cpol ^ ((t / brp) % 2 == 1)) : cfg_cpol;
    end
  end

  // comparison away from the edge, then drive miso for the next sample
  always @(negedge clk) begin
    #1;
    brp = int'(cfg_reload) + 1;
    kd  = mb ? t / brp : 0;
    if (cmp_en) begin
      bi = cfg_lead_sample ? kd / 2 : ((kd == 0) ? 0 : (kd - 1) / 2);
      exp_mosi  = (mb && !cfg_tx_off) ? w[posf(bi)] : cfg_idle_val;
      exp_ready = !cfg_tx_off && (!mb || (((t + 1) % brp == 0) &&
                  ((t + 1) / brp == 2 * (int'(cfg_len) + 1))));
      chk(busy == mb, "R9 busy", busy, mb);
      chk(sck == e_sck, "R2 sck", sck, e_sck);
      chk(mosi == exp_mosi, "R5 mosi", mosi, exp_mosi);
      chk(word_end == e_we, "R1 word_end", word_end, e_we);
      chk(rx_valid == e_rv, "R6 rx_valid", rx_valid, e_rv);
      chk(rx_data == e_rx, "R4 rx_data", rx_data, e_rx);
      chk(tx_underflow == e_uf, "R10 tx_underflow", tx_underflow, e_uf);
      chk(int'(rx_left) == m_left, "R7 rx_left", rx_left, m_left);
      chk(tx_ready == exp_ready, "R11 tx_ready", tx_ready, exp_ready);
    end
    miso = mb ? rx_pat[posf(kd / 2)] : 1'b0;
  end

  task automatic push(input logic [31:0] d);
    bit a;
    tx_data = d; tx_valid = 1'b1; a = 0;
    while (!a) begin
      #1 a = tx_ready;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    tx_valid = 1'b0;
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [4:0] len, input logic [15:0] br, input bit pol,
                         input bit lead, input bit msb, input bit txo, input bit rxof,
                         input bit idl);
    cfg_len = len; cfg_reload = br; cfg_cpol = pol; cfg_lead_sample = lead;
    cfg_msb_first = msb; cfg_tx_off = txo; cfg_rx_off = rxof; cfg_idle_val = idl;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0 && rx_valid == 0 && word_end == 0 && tx_underflow == 0, "R12 flags", busy, 0);
    chk(rx_left == 0 && rx_data == 0, "R12 regs", rx_left, 0);
    @(negedge clk);
    rst = 1'b0;
    cmp_en = 1;

    // full duplex, 8 bits, leading-edge sample, msb first
    rx_pat = 32'h0000_00B6;
    set_cfg(5'd7, 16'd1, 0, 1, 1, 0, 0, 1);
    #1 chk(mosi == 1'b1, "R8 idle mosi high", mosi, 1);
    @(negedge clk);
    push(32'h0000_00A5); push(32'h0000_003C); push(32'h0000_00F0);
    wait_idle();

    // tx only, 13 bits, idle high clock, trailing-edge sample, lsb first
    rx_pat = 32'h0000_1ACE;
    set_cfg(5'd12, 16'd0, 1, 0, 0, 0, 1, 0);
    #1 chk(sck == 1'b1, "R3 idle sck high", sck, 1);
    chk(mosi == 1'b0, "R8 idle mosi low", mosi, 0);
    @(negedge clk);
    push(32'h0000_1234); push(32'h0000_0F0F);
    wait_idle();
    #1 chk(rx_data == 32'h0000_00B6, "R6 rx_data held", rx_data, 32'h0000_00B6);
    @(negedge clk);

    // 32 bits, trailing-edge sample, msb first, slower clock
    rx_pat = 32'hC3A5_5A3C;
    set_cfg(5'd31, 16'd2, 0, 0, 1, 0, 0, 1);
    push(32'hDEAD_BEEF); push(32'h0123_4567);
    wait_idle();
    #1 chk(rx_data == 32'hC3A5_5A3C, "R4 rx word 32b", rx_data, 32'hC3A5_5A3C);
    @(negedge clk);

    // 1-bit words, both edge choices
    rx_pat = 32'h1;
    set_cfg(5'd0, 16'd0, 1, 1, 1, 0, 0, 0);
    push(32'h1); push(32'h0); push(32'h1);
    wait_idle();
    set_cfg(5'd0, 16'd3, 0, 0, 0, 0, 0, 1);
    push(32'h0); push(32'h1);
    wait_idle();

    // receive only: 3 bytes of 8-bit words, late request ignored
    rx_pat = 32'h0000_0069;
    set_cfg(5'd7, 16'd1, 0, 1, 1, 1, 0, 1);
    rxreq_bytes = 16'd3; rxreq_wr = 1'b1;
    @(negedge clk);
    rxreq_wr = 1'b0;
    repeat (10) @(negedge clk);
    rxreq_bytes = 16'd5; rxreq_wr = 1'b1;
    @(negedge clk);
    rxreq_wr = 1'b0;
    #1 chk(rx_left != 16'd5, "R7 request ignored", rx_left, 3);
    @(negedge clk);
    wait_idle();
    #1 chk(rx_left == 0 && mosi == 1'b1, "R7 budget drained", rx_left, 0);
    @(negedge clk);

    // receive only with 16-bit words: 3 bytes -> two words
    rx_pat = 32'h0000_9C3E;
    set_cfg(5'd15, 16'd0, 1, 0, 0, 1, 0, 0);
    rxreq_bytes = 16'd3; rxreq_wr = 1'b1;
    @(negedge clk);
    rxreq_wr = 1'b0;
    wait_idle();

    // both paths off: nothing starts
    set_cfg(5'd7, 16'd0, 0, 1, 1, 1, 1, 1);
    tx_data = 32'h55; tx_valid = 1'b1;
    rxreq_bytes = 16'd2; rxreq_wr = 1'b1;
    @(negedge clk);
    rxreq_wr = 1'b0;
    repeat (20) @(negedge clk);
    #1 chk(busy == 0 && tx_ready == 0, "R6 both off idle", busy, 0);
    tx_valid = 1'b0;
    repeat (3) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule